// File: doc/BRIEF.md
# SPI Read Data Packet Receiver

This block collects the data phase of an SPI read once the slave has accepted the read command. It asks a byte engine for one byte at a time and sends 0x00 on the outgoing line for each byte it clocks in. For each packet it first hunts for the start tag, which is any byte whose upper nibble is 0xF, and throws away every byte before it. It then streams the payload bytes out, and when checking is enabled it reads and verifies a 16-bit CRC after the payload. The run ends with a one-cycle done pulse that carries an error code.

There are two kinds of run. A single-word run reads exactly 4 payload bytes and accepts a short window of filler bytes before the tag. A block run reads a requested number of bytes, split into packets of at most `PKT_BYTES` bytes, and hunts for a fresh tag before each packet. The hunt in a block run allows a longer poll budget than the single-word window. For single-word reads aimed at the always-on register space (the clockless flag), the CRC bytes are still read to keep the framing, but they are not checked.

Top module: `spi_rdpkt_rx`

## Requirements
- R1: While hunting, every byte whose bits [7:4] are not 4'hF is discarded. The first byte with bits [7:4] = 4'hF is the tag, and the tag itself is never output. Each payload byte appears on `data_o` with `data_valid_o` high for one cycle, in the order received.
- R2: A single-word run (`single_i`=1) outputs exactly 4 payload bytes. Up to `FILL_WIN` (default 8) byte reads may be spent hunting. If none of them is a tag, the run ends with error code 1 (tag timeout) after exactly `FILL_WIN` bytes have been consumed.
- R3: In a block run, each packet's hunt may use at most `POLL_LIMIT`+1 byte reads (default 101). If that budget runs out, the run ends with error code 1 after exactly that many hunt reads.
- R4: A block run outputs `size_i` bytes in packets of min(remaining, `PKT_BYTES`), and each packet is preceded by its own tag. When `size_i` = 0, done is raised without reading any byte and the error code is 0.
- R5: With `crc_en_i`=1, two bytes follow each packet, high byte first. They must equal CRC-ITU-T (polynomial 0x1021, MSB first, initial value 0xFFFF, no final inversion) computed over that packet's payload. A mismatch ends the run with error code 2 right after that packet's CRC bytes.
- R6: In a single-word run with `clockless_i`=1 and `crc_en_i`=1, the two CRC bytes are consumed but never cause error code 2.
- R7: `tx_byte_o` is 0x00 on every byte the block clocks in.
- R8: `done_o` is a one-cycle pulse. `err_code_o` and `err_o` (1 when the code is nonzero) are valid with it and hold until the next start. After done, `req_o` stays low, and the number of bytes consumed is exactly what the framing calls for.
- R9: After reset the block is idle, with `req_o`, `busy_o`, `data_valid_o`, `done_o` and `err_o` all low.
- R10: While `busy_o` is high, `start_i` and the configuration inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run (accepted when idle) |
| single_i | input | 1 | 1: single-word run, 0: block run |
| clockless_i | input | 1 | Single-word run to always-on space (no CRC check) |
| crc_en_i | input | 1 | CRC16 bytes follow each packet |
| size_i | input | SIZE_W | Block run byte count |
| busy_o | output | 1 | Run in progress |
| req_o | output | 1 | Requesting the next byte |
| rx_valid_i | input | 1 | Byte engine has a byte; consumed when req_o is high |
| rx_byte_i | input | 8 | Received byte |
| tx_byte_o | output | 8 | Byte sent while receiving (always 0x00) |
| data_valid_o | output | 1 | Payload byte strobe |
| data_o | output | 8 | Payload byte |
| done_o | output | 1 | Run finished (one cycle) |
| err_o | output | 1 | Run ended with an error |
| err_code_o | output | 2 | 0 none, 1 tag timeout, 2 CRC mismatch |

## Verification
Several properties are checked on every cycle: done is a single-cycle pulse and requests stop after it, a payload strobe only follows a payload-state accept, the hunt counter never reaches its mode's budget, a CRC error needs CRC enabled and never occurs in a clockless single-word run, and the run configuration holds steady while busy. Other behaviour can only be shown by the bench's scenarios: the exact payload contents, where packets split, the position of the filler window and poll budget boundaries (7 versus 8 fillers, 100 versus 101), CRC byte order and value, the exact count of bytes consumed, and whether a start during a run is ignored.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HUNT, ST_DATA, ST_CRCH, ST_CRCL, ST_DONE
  } rx_state_e;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_TIMEOUT = 2'd1,
    ERR_CRC     = 2'd2
  } rx_err_e;

  localparam logic [3:0]  TAG_NIB  = 4'hF;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;
  localparam logic [15:0] CRC_POLY = 16'h1021;

  function automatic logic [15:0] crc16_byte(logic [15:0] crc, logic [7:0] b);
    logic [15:0] c;
    c = crc ^ {b, 8'h00};
    for (int i = 0; i < 8; i++) begin
      c = c[15] ? ((c << 1) ^ CRC_POLY) : (c << 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/spi_rx_crc16.sv
module spi_rx_crc16
  import spi_rx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        upd_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] crc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_o <= CRC_INIT;
    else if (clr_i)  crc_o <= CRC_INIT;
    else if (upd_i)  crc_o <= crc16_byte(crc_o, byte_i);
  end

  a_r5_crc_seed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> crc_o == CRC_INIT);
endmodule

// File: rtl/spi_rx_hunt.sv
module spi_rx_hunt #(
  parameter int FILL_WIN   = 8,
  parameter int POLL_LIMIT = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  input  logic single_i,
  output logic last_o
);
  localparam int MAXL = (FILL_WIN > POLL_LIMIT + 1) ? FILL_WIN : POLL_LIMIT + 1;
  localparam int CW   = $clog2(MAXL + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim    = single_i ? CW'(FILL_WIN) : CW'(POLL_LIMIT + 1);
  assign last_o = (cnt_q == lim - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (step_i && !last_o) cnt_q <= cnt_q + CW'(1);
  end

  a_r3_hunt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < lim);
  a_r2_hunt_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/spi_rdpkt_rx.sv
module spi_rdpkt_rx
  import spi_rx_pkg::*;
#(
  parameter int PKT_BYTES  = 8192,
  parameter int POLL_LIMIT = 100,
  parameter int FILL_WIN   = 8,
  parameter int SIZE_W     = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              single_i,
  input  logic              clockless_i,
  input  logic              crc_en_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              busy_o,
  output logic              req_o,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_byte_i,
  output logic [7:0]        tx_byte_o,
  output logic              data_valid_o,
  output logic [7:0]        data_o,
  output logic              done_o,
  output logic              err_o,
  output logic [1:0]        err_code_o
);
  localparam int                PKT_W  = $clog2(PKT_BYTES + 1);
  localparam logic [SIZE_W-1:0] PKT_SZ = SIZE_W'(PKT_BYTES);
  localparam logic [SIZE_W-1:0] WORD_SZ = SIZE_W'(4);

  rx_state_e         state_q;
  rx_err_e           err_q;
  logic              single_q, ckl_q, crc_en_q;
  logic [SIZE_W-1:0] rem_q;
  logic [PKT_W-1:0]  pkt_left_q, first_len;
  logic [7:0]        crc_hi_q;
  logic [15:0]       crc_val;
  logic              accept, is_tag, hunt_last, chk_crc;

  assign req_o     = (state_q == ST_HUNT) || (state_q == ST_DATA) ||
                     (state_q == ST_CRCH) || (state_q == ST_CRCL);
  assign accept    = req_o && rx_valid_i;
  assign is_tag    = (rx_byte_i[7:4] == TAG_NIB);
  assign first_len = PKT_W'((rem_q > PKT_SZ) ? PKT_SZ : rem_q);
  assign chk_crc   = !(single_q && ckl_q);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign err_code_o = err_q;
  assign err_o     = (err_q != ERR_NONE);
  assign tx_byte_o = 8'h00;

  spi_rx_hunt #(.FILL_WIN(FILL_WIN), .POLL_LIMIT(POLL_LIMIT)) u_hunt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (state_q != ST_HUNT),
    .step_i   ((state_q == ST_HUNT) && accept && !is_tag),
    .single_i (single_q),
    .last_o   (hunt_last)
  );

  spi_rx_crc16 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q == ST_HUNT),
    .upd_i  ((state_q == ST_DATA) && accept),
    .byte_i (rx_byte_i),
    .crc_o  (crc_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      err_q      <= ERR_NONE;
      single_q   <= 1'b0;
      ckl_q      <= 1'b0;
      crc_en_q   <= 1'b0;
      rem_q      <= '0;
      pkt_left_q <= '0;
      crc_hi_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          single_q <= single_i;
          ckl_q    <= clockless_i;
          crc_en_q <= crc_en_i;
          err_q    <= ERR_NONE;
          rem_q    <= single_i ? WORD_SZ : size_i;
          state_q  <= (!single_i && size_i == '0) ? ST_DONE : ST_HUNT;
        end
        ST_HUNT: if (accept) begin
          if (is_tag) begin
            pkt_left_q <= first_len;
            state_q    <= ST_DATA;
          end else if (hunt_last) begin
            err_q   <= ERR_TIMEOUT;
            state_q <= ST_DONE;
          end
        end
        ST_DATA: if (accept) begin
          pkt_left_q <= pkt_left_q - PKT_W'(1);
          rem_q      <= rem_q - SIZE_W'(1);
          if (pkt_left_q == PKT_W'(1)) begin
            if (crc_en_q)                 state_q <= ST_CRCH;
            else if (rem_q == SIZE_W'(1)) state_q <= ST_DONE;
            else                          state_q <= ST_HUNT;
          end
        end
        ST_CRCH: if (accept) begin
          crc_hi_q <= rx_byte_i;
          state_q  <= ST_CRCL;
        end
        ST_CRCL: if (accept) begin
          if (chk_crc && ({crc_hi_q, rx_byte_i} != crc_val)) begin
            err_q   <= ERR_CRC;
            state_q <= ST_DONE;
          end else begin
            state_q <= (rem_q == '0) ? ST_DONE : ST_HUNT;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_valid_o <= 1'b0;
      data_o       <= '0;
    end else begin
      data_valid_o <= (state_q == ST_DATA) && accept;
      if ((state_q == ST_DATA) && accept) data_o <= rx_byte_i;
    end
  end

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_quiet_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !req_o);
  a_r1_strobe_from_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> $past(state_q == ST_DATA));
  a_r5_crc_err_needs_crc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_code_o == ERR_CRC) |-> crc_en_q);
  a_r6_clockless_no_crc_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && single_q && ckl_q) |-> err_code_o != ERR_CRC);
  a_r10_cfg_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(single_q) && $stable(crc_en_q) && $stable(ckl_q)));
  a_r4_data_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA) |-> (pkt_left_q != '0 && rem_q != '0));
endmodule

// File: tb/spi_rdpkt_rx_bench.sv
module spi_rdpkt_rx_bench;
  localparam int PKT    = 16;
  localparam int POLL   = 100;
  localparam int FWIN   = 8;
  localparam int SIZE_W = 24;

  logic clk = 0, rst_n = 0;
  logic start_i = 0, single_i = 0, clockless_i = 0, crc_en_i = 0;
  logic [SIZE_W-1:0] size_i = '0;
  logic rx_valid_i = 0;
  logic [7:0] rx_byte_i = '0;
  logic busy_o, req_o, data_valid_o, done_o, err_o;
  logic [7:0] tx_byte_o, data_o;
  logic [1:0] err_code_o;

  int checks = 0, errors = 0;
  int fills[8];

  always #2 clk = ~clk;

  spi_rdpkt_rx #(.PKT_BYTES(PKT), .POLL_LIMIT(POLL), .FILL_WIN(FWIN), .SIZE_W(SIZE_W))
  u_spi_rdpkt_rx (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .single_i(single_i),
    .clockless_i(clockless_i), .crc_en_i(crc_en_i), .size_i(size_i),
    .busy_o(busy_o), .req_o(req_o), .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i),
    .tx_byte_o(tx_byte_o), .data_valid_o(data_valid_o), .data_o(data_o),
    .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o)
  );

  task automatic chk(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(logic [15:0] c, logic [7:0] b);
    for (int k = 7; k >= 0; k--) begin
      logic fb;
      fb = c[15] ^ b[k];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  task automatic run(string rq, bit sg, bit ck, bit ce, int sz, int bad, bit poke);
    logic [7:0] stream[$];
    logic [7:0] expd[$];
    logic [7:0] got[$];
    int lim, rem, pk, exp_err, exp_use, idx, ec, eo;
    bit pend, seen, txbad, extra;
    lim = sg ? FWIN : POLL + 1;
    rem = sg ? 4 : sz;
    pk = 0; exp_err = 0; exp_use = 0;
    while (rem > 0 && exp_err == 0) begin
      int n, f;
      logic [15:0] c;
      n = (rem > PKT) ? PKT : rem;
      f = fills[pk % 8];
      for (int j = 0; j < f; j++) stream.push_back(8'($urandom) & 8'h7F);
      if (f >= lim) begin
        exp_use += lim; exp_err = 1;
        break;
      end
      stream.push_back(8'hF0 | 8'($urandom % 16));
      exp_use += f + 1;
      c = 16'hFFFF;
      for (int j = 0; j < n; j++) begin
        logic [7:0] b;
        b = 8'($urandom);
        stream.push_back(b); expd.push_back(b);
        c = ref_crc(c, b);
      end
      exp_use += n;
      if (ce) begin
        if (pk == bad) c = c ^ 16'h0101;
        stream.push_back(c[15:8]); stream.push_back(c[7:0]);
        exp_use += 2;
        if (pk == bad && !(sg && ck)) exp_err = 2;
      end
      rem -= n; pk++;
    end
    for (int j = 0; j < 8; j++) stream.push_back(8'hF5);

    @(negedge clk);
    single_i = sg; clockless_i = ck; crc_en_i = ce; size_i = SIZE_W'(sz);
    start_i = 1; rx_valid_i = 0;
    idx = 0; pend = 0; seen = 0; txbad = 0; ec = 0; eo = 0;
    for (int it = 0; it < 6000; it++) begin
      @(negedge clk);
      if (pend) idx++;
      if (data_valid_o) got.push_back(data_o);
      if (done_o) begin
        seen = 1; ec = err_code_o; eo = err_o;
        break;
      end
      if (req_o && tx_byte_o != 8'h00) txbad = 1;
      start_i = (poke && it == 5);
      if (poke && it == 5) begin single_i = ~sg; size_i = SIZE_W'(3); end
      rx_valid_i = ($urandom % 4) != 0;
      rx_byte_i  = (idx < stream.size()) ? stream[idx] : 8'h00;
      pend = req_o && rx_valid_i;
    end
    start_i = 0; rx_valid_i = 0;
    chk(seen, {rq, " watchdog/done"}, seen, 1);
    chk(ec == exp_err, {rq, " err_code"}, ec, exp_err);
    chk(eo == (exp_err != 0), {rq, " R8 err_o"}, eo, exp_err != 0);
    chk(got.size() == expd.size(), {rq, " payload count"}, got.size(), expd.size());
    for (int j = 0; j < got.size() && j < expd.size(); j++)
      if (got[j] !== expd[j]) begin
        chk(0, {rq, " R1 payload byte"}, got[j], expd[j]);
        break;
      end
    chk(idx == exp_use, {rq, " R8 bytes consumed"}, idx, exp_use);
    chk(!txbad, {rq, " R7 tx zero"}, txbad, 0);
    extra = 0;
    repeat (3) begin
      @(negedge clk);
      if (req_o || data_valid_o || done_o) extra = 1;
    end
    chk(!extra, {rq, " R8 idle after done"}, extra, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk(!req_o && !busy_o && !data_valid_o && !done_o && !err_o, "R9 reset state",
        {req_o, busy_o, data_valid_o, done_o, err_o}, 0);
    rst_n = 1;
    @(negedge clk);

    foreach (fills[k]) fills[k] = 0;
    run("R1 R2 single no filler", 1, 0, 0, 0, -1, 0);
    fills[0] = 7; run("R2 single 7 fillers", 1, 0, 0, 0, -1, 0);
    fills[0] = 8; run("R2 single 8 fillers timeout", 1, 0, 0, 0, -1, 0);
    fills[0] = 3; run("R5 single crc good", 1, 0, 1, 0, -1, 0);
    run("R5 single crc bad", 1, 0, 1, 0, 0, 0);
    run("R6 clockless crc bad ignored", 1, 1, 1, 0, 0, 0);
    foreach (fills[k]) fills[k] = k + 1;
    run("R4 R5 block 40 crc", 0, 0, 1, 40, -1, 0);
    run("R4 block 32 exact packets", 0, 0, 0, 32, -1, 0);
    run("R5 block crc bad pkt1", 0, 0, 1, 40, 1, 0);
    run("R6 block clockless still checked", 0, 1, 1, 20, 0, 0);
    fills[0] = 100; run("R3 block 100 fillers", 0, 0, 0, 10, -1, 0);
    fills[0] = 101; run("R3 block 101 fillers timeout", 0, 0, 0, 10, -1, 0);
    fills[0] = 2; fills[1] = 101; run("R3 timeout second packet", 0, 0, 1, 24, -1, 0);
    run("R4 block size zero", 0, 0, 1, 0, -1, 0);
    foreach (fills[k]) fills[k] = 2;
    run("R10 start ignored while busy", 0, 0, 1, 40, -1, 1);

    for (int r = 0; r < 25; r++) begin
      bit sg, ck, ce;
      int sz, bad;
      sg = ($urandom % 3) == 0;
      ck = $urandom % 2;
      ce = $urandom % 2;
      sz = 1 + $urandom % 50;
      foreach (fills[k]) fills[k] = ($urandom % 5 == 0) ? $urandom % 12 : $urandom % 4;
      bad = ($urandom % 4 == 0) ? int'($urandom % 4) : -1;
      run("R1 R4 R5 random", sg, ck, ce, sz, bad, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule